// File: doc/BRIEF.md
# Chainable Dual 8-bit Compare Timer

This block holds two 8-bit up-counters, a low timer and a high timer, each with its own compare register. Both advance on a prescaled tick strobe supplied from outside. In split mode, each counter clears and raises a one-cycle interrupt when it reaches its compare value. The high timer can take its count from the low timer's compare match instead of from the tick, which gives a cascaded divider.

In joined mode the two counters form one 16-bit counter that only the low timer's tick drives. The pair fires only when both bytes match together. At that point both bytes clear and both interrupts pulse in the same cycle. Two further mode codes, pulse and width, count exactly like split mode and drive no waveform.

Software programs the block through a small write-only register port. The run register holds a per-timer run bit and a shared prescaler-run bit. The mode and clock-select registers carry one field for each pair position, chosen by a parameter. Two compare registers complete the port. The counter values are brought out so that the integrating logic can watch them.

Top module: `tmr_pair_top`

## Requirements
- R1: After a synchronous active-low reset, both counters, both interrupt outputs and every control register are zero. With all registers at zero, ticks change nothing.
- R2: A timer advances only when two bits of the run register (address 0) are both set: its own run bit and the shared prescaler-run bit, bit 5. The low timer's run bit is bit 2·PAIR_IDX and the high timer's is the next bit up. If either bit is cleared, the timer holds its value.
- R3: A write to the run register that takes a timer's run bit from 0 to 1 clears that timer's counter to zero. A write that leaves the bit at 1 does not clear it.
- R4: In split mode (mode code 0) each tick adds one to a running low timer. When the incremented value equals its compare register (address 3), the counter becomes zero instead.
- R5: Each interrupt output is high for the one cycle after the clock edge that captured its match, and is low otherwise.
- R6: In split mode, the high timer's clock-select field sits at bits 4·PAIR_IDX+3..4·PAIR_IDX+2 of the register at address 2. When that field is 0, the high timer adds one for each low-timer match. When the field is nonzero, it adds one for each tick. In both cases it matches and clears against the compare register at address 4.
- R7: In joined mode (mode code 1) only the low timer's run state and the tick matter. A low byte that wraps from 255 to 0 adds one to the high byte.
- R8: In joined mode a match needs both conditions together: the low byte equals compare address 3, and the high byte equals compare address 4. On such a match both bytes clear and both interrupts pulse in the same cycle. A match of the low byte alone fires nothing.
- R9: Mode codes 2 and 3 count, clear and interrupt exactly as mode code 0.
- R10: The mode field is bits 2·PAIR_IDX+3..2·PAIR_IDX+2 of the register at address 1. Other bits of that register are ignored. Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescaled count strobe, one cycle wide |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| irq_lo | output | 1 | Low timer interrupt pulse |
| irq_hi | output | 1 | High timer interrupt pulse |
| cnt_lo | output | 8 | Low timer count |
| cnt_hi | output | 8 | High timer count |

## Verification
The assertions take several things for granted about the inputs:
- the tick, the write strobe, the address and the data are known, synchronous values whenever reset is released;
- reset is held for at least one edge before the first property is sampled.

The joined-mode check reads the mode held in the previous cycle, so it tolerates a mode write at any time. The counter-hold check allows for a run-bit clear landing in the same cycle as a carry.

The stimulus meets these assumptions in the following way:
- every input is driven from the falling edge, starting at time zero;
- each register write is held for exactly one cycle, with the tick low;
- the tick spacing changes between scenarios, so that matches occur both on back-to-back ticks and on sparse ones.

// File: rtl/tmr_pair_pkg.sv
// Shared types and register addresses for the chainable timer pair.
// Assumes a byte-wide register port and at most two pair positions.
package tmr_pair_pkg;

    typedef enum logic [1:0] {
        MODE_SPLIT8   = 2'd0,
        MODE_JOINED16 = 2'd1,
        MODE_PULSE    = 2'd2,
        MODE_WIDTH    = 2'd3
    } pair_mode_e;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_RUN    = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE   = 3'd1;
    localparam logic [ADDR_W-1:0] A_CSEL   = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd4;

endpackage

// File: rtl/tmr_pair_regs.sv
// Control register file of the timer pair.
// It keeps only the bits that belong to this pair position and decodes from them:
//   - the run enables,
//   - the start-clear pulses,
//   - the mode,
//   - the cascade select.
// Assumes DW is at least 8 (the prescaler bit is bit 5) and CW <= DW.
module tmr_pair_regs
    import tmr_pair_pkg::*;
#(
    parameter int unsigned DW       = 8,
    parameter int unsigned CW       = 8,
    parameter int unsigned PAIR_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [1:0]        en,
    output logic [1:0]        start_clr,
    output pair_mode_e        mode,
    output logic              cascade,
    output logic [CW-1:0]     cmp_lo,
    output logic [CW-1:0]     cmp_hi
);

    localparam int unsigned RUN_POS  = PAIR_IDX * 2;
    localparam int unsigned PRE_BIT  = 5;
    localparam int unsigned MODE_POS = PAIR_IDX * 2 + 2;
    localparam int unsigned CSEL_POS = PAIR_IDX * 4 + 2;

    logic [1:0]    run_q;
    logic          pre_q;
    pair_mode_e    mode_q;
    logic [1:0]    csel_q;
    logic [CW-1:0] cmp_q [2];
    logic          wr_run;

    assign wr_run = we && (addr == A_RUN);

    // Register writes: keep only this pair's fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= '0;
            pre_q    <= 1'b0;
            mode_q   <= MODE_SPLIT8;
            csel_q   <= '0;
            cmp_q[0] <= '0;
            cmp_q[1] <= '0;
        end else if (we) begin
            case (addr)
                A_RUN: begin
                    run_q <= wdata[RUN_POS +: 2];
                    pre_q <= wdata[PRE_BIT];
                end
                A_MODE:   mode_q   <= pair_mode_e'(wdata[MODE_POS +: 2]);
                A_CSEL:   csel_q   <= wdata[CSEL_POS +: 2];
                A_CMP_LO: cmp_q[0] <= wdata[CW-1:0];
                A_CMP_HI: cmp_q[1] <= wdata[CW-1:0];
                default: ;
            endcase
        end
    end

    // Per-timer run enable and start-clear on a 0-to-1 run-bit write.
    for (genvar k = 0; k < 2; k++) begin : g_run
        assign en[k]        = run_q[k] & pre_q;
        assign start_clr[k] = wr_run & wdata[RUN_POS + k] & ~run_q[k];
    end

    assign mode    = mode_q;
    assign cascade = (csel_q == 2'b00);
    assign cmp_lo  = cmp_q[0];
    assign cmp_hi  = cmp_q[1];

endmodule

// File: rtl/tmr_pair_cnt.sv
// One up-counter cell.
// It offers its incremented value so that the pair logic can compare it before the edge.
// Assumes that clear takes priority over step.
module tmr_pair_cnt #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          clr,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] nxt
);

    assign nxt = cnt_q + 1'b1;

    // Counter state: clear, step or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (clr)  cnt_q <= '0;
        else if (step) cnt_q <= nxt;
    end

    // R2: with no step and no clear the value holds.
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(cnt_q));

    // R3: a clear request leaves the counter at zero.
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/tmr_pair_link.sv
// Pair sequencing logic. It decides which cell steps on this cycle, and it compares
// the incremented values with the compare registers:
//   - in split mode, each byte alone;
//   - in joined mode, both bytes together.
// It raises the clear requests and registers the interrupt pulses.
// Assumes the cells add one when stepped and wrap at all-ones.
module tmr_pair_link
    import tmr_pair_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [1:0]    en,
    input  pair_mode_e    mode,
    input  logic          cascade,
    input  logic [CW-1:0] cmp_lo,
    input  logic [CW-1:0] cmp_hi,
    input  logic [CW-1:0] cnt_lo,
    input  logic [CW-1:0] cnt_hi,
    input  logic [CW-1:0] nxt_lo,
    input  logic [CW-1:0] nxt_hi,
    output logic [1:0]    step,
    output logic [1:0]    mclr,
    output logic          irq_lo,
    output logic          irq_hi
);

    logic          wrap_lo;
    logic [CW-1:0] hi_next;
    logic          hit_lo;
    logic          hit_hi;
    logic [1:0]    fire;

    assign wrap_lo = (cnt_lo == {CW{1'b1}});

    // Step and match decode for the selected mode.
    always_comb begin
        step    = '0;
        hit_lo  = 1'b0;
        hit_hi  = 1'b0;
        hi_next = cnt_hi;
        if (mode == MODE_JOINED16) begin
            step[0] = tick & en[0];
            step[1] = step[0] & wrap_lo;
            hi_next = step[1] ? nxt_hi : cnt_hi;
            hit_lo  = step[0] && (nxt_lo == cmp_lo) && (hi_next == cmp_hi);
            hit_hi  = hit_lo;
        end else begin
            step[0] = tick & en[0];
            hit_lo  = step[0] && (nxt_lo == cmp_lo);
            step[1] = en[1] & (cascade ? hit_lo : tick);
            hit_hi  = step[1] && (nxt_hi == cmp_hi);
        end
    end

    assign fire = {hit_hi, hit_lo};
    assign mclr = fire;

    // Interrupt pulses, one cycle after the matching edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_lo <= 1'b0;
            irq_hi <= 1'b0;
        end else begin
            irq_lo <= fire[0];
            irq_hi <= fire[1];
        end
    end

    // R8: a joined-mode high interrupt always comes with the low one.
    a_r8_joint_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi && ($past(mode) == MODE_JOINED16)) |-> irq_lo);

endmodule

// File: rtl/tmr_pair_top.sv
// Chainable dual 8-bit compare timer. This top instantiates:
//   - the register file,
//   - two counter cells,
//   - the pair logic.
// Assumes tick is a synchronous strobe from an external prescaler.
module tmr_pair_top
    import tmr_pair_pkg::*;
#(
    parameter int unsigned DW       = 8,
    parameter int unsigned CW       = 8,
    parameter int unsigned PAIR_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic              irq_lo,
    output logic              irq_hi,
    output logic [CW-1:0]     cnt_lo,
    output logic [CW-1:0]     cnt_hi
);

    logic [1:0]    en;
    logic [1:0]    start_clr;
    pair_mode_e    mode;
    logic          cascade;
    logic [CW-1:0] cmp_lo;
    logic [CW-1:0] cmp_hi;
    logic [1:0]    step_v;
    logic [1:0]    mclr_v;
    logic [CW-1:0] cnt_v [2];
    logic [CW-1:0] nxt_v [2];

    tmr_pair_regs #(.DW(DW), .CW(CW), .PAIR_IDX(PAIR_IDX)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .en        (en),
        .start_clr (start_clr),
        .mode      (mode),
        .cascade   (cascade),
        .cmp_lo    (cmp_lo),
        .cmp_hi    (cmp_hi)
    );

    for (genvar k = 0; k < 2; k++) begin : g_cell
        tmr_pair_cnt #(.CW(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (step_v[k]),
            .clr   (start_clr[k] | mclr_v[k]),
            .cnt_q (cnt_v[k]),
            .nxt   (nxt_v[k])
        );
    end

    tmr_pair_link #(.CW(CW)) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .en      (en),
        .mode    (mode),
        .cascade (cascade),
        .cmp_lo  (cmp_lo),
        .cmp_hi  (cmp_hi),
        .cnt_lo  (cnt_v[0]),
        .cnt_hi  (cnt_v[1]),
        .nxt_lo  (nxt_v[0]),
        .nxt_hi  (nxt_v[1]),
        .step    (step_v),
        .mclr    (mclr_v),
        .irq_lo  (irq_lo),
        .irq_hi  (irq_hi)
    );

    assign cnt_lo = cnt_v[0];
    assign cnt_hi = cnt_v[1];

    // R4: a low interrupt is seen together with a cleared low counter.
    a_r4_irq_lo_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> (cnt_lo == '0));

    // R6: a high interrupt is seen together with a cleared high counter.
    a_r6_irq_hi_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> (cnt_hi == '0));

    // R7: in joined mode the high byte is still on a cycle with no tick.
    a_r7_hi_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_JOINED16 && !tick && !start_clr[1]) |=> $stable(cnt_hi));

endmodule

// File: tb/tmr_pair_top_test.sv
// Self-checking bench. A behavioural integer model runs on each rising edge,
// and the model and the design outputs are compared on each falling edge.
module tmr_pair_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       we = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic       irq_lo, irq_hi;
    logic [7:0] cnt_lo, cnt_hi;

    always #10 clk = ~clk;

    tmr_pair_top uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .irq_lo(irq_lo), .irq_hi(irq_hi),
        .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
    );

    // Reference model state.
    int m_run, m_mode, m_csel, m_cmp0, m_cmp1, m_c0, m_c1;
    bit m_i0, m_i1;
    string cur_req = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_mode = 0; m_csel = 0; m_cmp0 = 0; m_cmp1 = 0;
            m_c0 = 0; m_c1 = 0; m_i0 = 0; m_i1 = 0;
        end else begin
            bit r0, r1, em;
            int md, lo, hi;
            m_i0 = 0; m_i1 = 0;
            r0 = m_run[0] && m_run[5];
            r1 = m_run[1] && m_run[5];
            md = (m_mode >> 2) & 3;
            if (tick) begin
                if (md == 1) begin
                    if (r0) begin
                        lo = m_c0 + 1; hi = m_c1;
                        if (lo == 256) begin lo = 0; hi = (hi + 1) % 256; end
                        if (lo == m_cmp0 && hi == m_cmp1) begin
                            lo = 0; hi = 0; m_i0 = 1; m_i1 = 1;
                        end
                        m_c0 = lo; m_c1 = hi;
                    end
                end else begin
                    em = 0;
                    if (r0) begin
                        lo = (m_c0 + 1) % 256;
                        if (lo == m_cmp0) begin lo = 0; em = 1; m_i0 = 1; end
                        m_c0 = lo;
                    end
                    if (r1 && ((((m_csel >> 2) & 3) == 0) ? em : 1'b1)) begin
                        hi = (m_c1 + 1) % 256;
                        if (hi == m_cmp1) begin hi = 0; m_i1 = 1; end
                        m_c1 = hi;
                    end
                end
            end
            if (we) begin
                case (addr)
                    3'd0: begin
                        if (wdata[0] && !m_run[0]) m_c0 = 0;
                        if (wdata[1] && !m_run[1]) m_c1 = 0;
                        m_run = wdata;
                    end
                    3'd1: m_mode = wdata;
                    3'd2: m_csel = wdata;
                    3'd3: m_cmp0 = wdata;
                    3'd4: m_cmp1 = wdata;
                    default: ;
                endcase
            end
        end
    end

    // Per-clock comparison and interrupt pulse counting.
    int n_vec = 0, n_vec_bad = 0, np_lo = 0, np_hi = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            n_vec++;
            if (irq_lo !== m_i0 || irq_hi !== m_i1 || cnt_lo !== m_c0[7:0] || cnt_hi !== m_c1[7:0]) begin
                n_vec_bad++;
                $display("FAIL %s clock compare: got irq=%b%b cnt=%0d/%0d, expected irq=%b%b cnt=%0d/%0d",
                         cur_req, irq_hi, irq_lo, cnt_hi, cnt_lo, m_i1, m_i0, m_c1, m_c0);
            end
            if (irq_lo === 1'b1) np_lo++;
            if (irq_hi === 1'b1) np_hi++;
        end
    end

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec + n_chk + 1, n_vec_bad + n_bad + 1);
            $finish;
        end
    end

    task automatic expect_val(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d, expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); tick = 1'b0; we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic spin(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = ((i % gap) == 0);
        end
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    int b_lo, b_hi;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, and no effect from ticks with all registers zero.
        cur_req = "R1";
        expect_val("R1", "cnt_lo after reset", cnt_lo, 0);
        expect_val("R1", "cnt_hi after reset", cnt_hi, 0);
        expect_val("R1", "irq after reset", {irq_hi, irq_lo}, 0);
        spin(10, 1);
        expect_val("R1", "cnt_lo idle ticks", cnt_lo, 0);

        // R4 and R5: split mode, compare 5, back-to-back ticks.
        cur_req = "R4/R5";
        wr(3'd3, 8'd5);
        wr(3'd0, 8'h21);
        b_lo = np_lo;
        spin(40, 1);
        expect_val("R4", "low matches in 40 ticks", np_lo - b_lo, 8);
        b_lo = np_lo;
        spin(21, 3);
        expect_val("R5", "low pulses at sparse ticks", np_lo - b_lo, 1);

        // R2 and R3: the run bits gate counting; a start clears the counter.
        cur_req = "R2";
        wr(3'd3, 8'd200);
        wr(3'd0, 8'h20);
        wr(3'd0, 8'h21);
        spin(10, 1);
        expect_val("R2", "counted value", cnt_lo, 10);
        wr(3'd0, 8'h01);
        spin(10, 1);
        expect_val("R2", "held with prescaler bit clear", cnt_lo, 10);
        cur_req = "R3";
        wr(3'd0, 8'h21);
        spin(5, 1);
        expect_val("R3", "no clear when bit stays set", cnt_lo, 15);
        wr(3'd0, 8'h20);
        spin(4, 1);
        expect_val("R2", "held with own bit clear", cnt_lo, 15);
        wr(3'd0, 8'h21);
        expect_val("R3", "cleared by start", cnt_lo, 0);

        // R6: cascade from the low match, then the high timer counts on ticks.
        cur_req = "R6";
        wr(3'd3, 8'd5);
        wr(3'd4, 8'd3);
        wr(3'd0, 8'h20);
        wr(3'd0, 8'h23);
        b_hi = np_hi;
        spin(60, 2);
        expect_val("R6", "cascaded high matches", np_hi - b_hi, 2);
        wr(3'd2, 8'h04);
        wr(3'd0, 8'h20);
        wr(3'd0, 8'h23);
        b_hi = np_hi;
        spin(30, 1);
        expect_val("R6", "tick-clocked high matches", np_hi - b_hi, 10);
        wr(3'd2, 8'h00);

        // R9: the pulse and width codes count like split mode.
        cur_req = "R9";
        wr(3'd3, 8'd4);
        foreach (b_lo_modes[j]) begin
            wr(3'd1, b_lo_modes[j]);
            wr(3'd0, 8'h20);
            wr(3'd0, 8'h21);
            b_lo = np_lo;
            spin(20, 1);
            expect_val("R9", "low matches in mode 2/3", np_lo - b_lo, 5);
        end

        // R7 and R8: joined mode with compare 0x0210.
        cur_req = "R7/R8";
        wr(3'd1, 8'h04);
        wr(3'd3, 8'h10);
        wr(3'd4, 8'h02);
        wr(3'd0, 8'h20);
        wr(3'd0, 8'h21);
        b_lo = np_lo; b_hi = np_hi;
        spin(300, 1);
        expect_val("R7", "low byte after carry", cnt_lo, 44);
        expect_val("R7", "high byte after carry", cnt_hi, 1);
        expect_val("R8", "no fire on low-only match", np_lo - b_lo, 0);
        spin(228, 1);
        expect_val("R8", "joint low pulses", np_lo - b_lo, 1);
        expect_val("R8", "joint high pulses", np_hi - b_hi, 1);
        expect_val("R8", "both bytes cleared", {cnt_hi, cnt_lo}, 0);

        // R10: only the pair's mode field matters; unmapped addresses are ignored.
        cur_req = "R10";
        wr(3'd1, 8'hF4);
        wr(3'd3, 8'd4);
        wr(3'd7, 8'hFF);
        wr(3'd5, 8'h00);
        b_lo = np_lo;
        spin(20, 1);
        expect_val("R10", "joined mode kept with stray bits", np_lo - b_lo, 0);
        expect_val("R10", "low byte still counting", cnt_lo, 20);
        wr(3'd1, 8'hF3);
        wr(3'd0, 8'h20);
        wr(3'd0, 8'h21);
        b_lo = np_lo;
        spin(20, 1);
        expect_val("R10", "split mode with stray bits", np_lo - b_lo, 5);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec + n_chk, n_vec_bad + n_bad);
        $finish;
    end

    logic [7:0] b_lo_modes [2] = '{8'h08, 8'h0C};

endmodule